// File: doc/BRIEF.md
# Multiplexed Host Bus Front End

This block sits between an external host and the register file and FIFOs of a processor's host port. The host shares one bus for address and data. Each transfer is framed by a strobe, built from a chip select and two data strobe pins. A two-bit cycle code and a read/not-write pin tell the block what kind of access the host wants. The block turns every host transfer into a single-cycle write or read request toward the internal side, tagged with the cycle code.

The bus width is set by a mode pin that is sampled during reset. In the narrow mode a 32-bit word travels as two 16-bit halfwords, and a second-halfword pin tells them apart. In the wide mode each strobe carries a full word. The host may pulse an optional address-latch strobe ahead of the data strobe, so that the cycle information is captured early. The block pulls its ready output low only for data cycles, and only while the internal side has no read data or no write space.

All host pins are sampled on the block clock. The edges of the strobe and of the address-latch strobe are found by comparing each pin with its value one cycle earlier.

Top module: `hpbus_front`

## Requirements
- R1: After reset, `ready_o` is 1, `bus_oe_o` is 0, and neither `req_wr_o` nor `req_rd_o` is asserted.
- R2: The strobe is active only when `sel_n_i`=0, `dstb0_n_i`=0 and `dstb1_i`=1 at the same time. No other combination issues any request.
- R3: `req_kind_o` carries the cycle code taken at strobe start. The codes are: 0 = control register, 1 = data with address increment, 2 = address register, 3 = data with fixed address.
- R4: A falling edge on `ale_n_i` captures `cyc_i`, `rnw_i` and `second_i`. Those captured values are used at the next strobe start, whatever the pins show then. If no such edge came first, the pins are sampled at strobe start.
- R5: In narrow mode, a write with `second_i`=0 stores `bus_i[15:0]` as the upper half and issues no request. The following write with `second_i`=1 issues one `req_wr_o` pulse, in the cycle after strobe start, with `req_wdata_o` = {stored half, `bus_i[15:0]`}.
- R6: In narrow mode, a single control-register write halfword issues `req_wr_o` at once, with `bus_i[15:0]` copied into both halves of `req_wdata_o`.
- R7: In narrow mode, a read with `second_i`=0 issues `req_rd_o` and captures `resp_data_i`. One cycle after the request, `bus_o[15:0]` shows bits 31:16 of the captured word. A read with `second_i`=1 issues no request and shows bits 15:0.
- R8: In wide mode, every strobe moves a full 32-bit word. A write sends `bus_i` as `req_wdata_o`, and a read shows the captured word on `bus_o`.
- R9: Control-register and address-register cycles never lower `ready_o`. A read that must fetch data keeps `ready_o` low while `rd_avail_i`=0. A data write that completes a word keeps `ready_o` low while `wr_space_i`=0. In the cycle after the condition clears, `ready_o` returns high together with the request pulse.
- R10: `bus_oe_o` is 1 exactly while the strobe is active and `rnw_i`=1.
- R11: The bus width is fixed by `wide_mode_i` at reset. Changing the pin later has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode_i | input | 1 | Bus width select (1 = 32-bit), sampled during reset |
| sel_n_i | input | 1 | Host chip select, active low |
| dstb0_n_i | input | 1 | Host data strobe, active low |
| dstb1_i | input | 1 | Host data strobe, active high |
| ale_n_i | input | 1 | Optional address-latch strobe, tie high if unused |
| rnw_i | input | 1 | Direction, 1 = host reads |
| second_i | input | 1 | Halfword identify, 1 = second halfword |
| cyc_i | input | 2 | Cycle code |
| bus_i | input | 32 | Host bus, inbound |
| bus_o | output | 32 | Host bus, outbound |
| bus_oe_o | output | 1 | Output enable for the host bus |
| ready_o | output | 1 | Ready toward the host |
| req_wr_o | output | 1 | Single-cycle write request |
| req_rd_o | output | 1 | Single-cycle read request |
| req_kind_o | output | 2 | Cycle code of the current request |
| req_wdata_o | output | 32 | Assembled write word |
| resp_data_i | input | 32 | Read word, valid in the cycle of `req_rd_o` |
| rd_avail_i | input | 1 | Read data available |
| wr_space_i | input | 1 | Write space available |

## Verification
A stale or corrupted stored upper half appears in `req_wdata_o` in the very cycle the second halfword's request fires. A cycle left stuck in the waiting phase holds `ready_o` low. That shows up on the next control or address access, one cycle after its strobe starts. If the latch flag for the address-latch strobe is not cleared, every later transfer carries the old cycle code on `req_kind_o`. This is visible one cycle after the next strobe start. A wrongly captured width shows up as a missing or extra request on the first write after reset.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
    typedef enum logic [1:0] {
        K_CTRL     = 2'd0,
        K_DATA_INC = 2'd1,
        K_ADDR     = 2'd2,
        K_DATA_FIX = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_WAIT   = 2'd2
    } phase_e;

    typedef struct packed {
        kind_e kind;
        logic  rd;
        logic  second;
    } cyc_t;
endpackage

// File: rtl/hpb_strobe.sv
module hpb_strobe
    import hpb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n_i,
    input  logic       dstb0_n_i,
    input  logic       dstb1_i,
    input  logic       ale_n_i,
    input  logic       rnw_i,
    input  logic       second_i,
    input  logic [1:0] cyc_i,
    output logic       strb_o,
    output logic       start_o,
    output cyc_t       eff_o
);
    typedef struct packed {
        logic strb_prev;
        logic ale_prev;
        logic held;
        cyc_t lat;
    } st_t;

    st_t  d, q;
    cyc_t pins;

    always_comb begin
        pins.kind   = kind_e'(cyc_i);
        pins.rd     = rnw_i;
        pins.second = second_i;
        strb_o  = !sel_n_i && !dstb0_n_i && dstb1_i;
        start_o = strb_o && !q.strb_prev;
        eff_o   = q.held ? q.lat : pins;
        d = q;
        d.strb_prev = strb_o;
        d.ale_prev  = ale_n_i;
        if (q.ale_prev && !ale_n_i) begin
            d.held = 1'b1;
            d.lat  = pins;
        end else if (q.strb_prev && !strb_o) begin
            d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{strb_prev: 1'b0, ale_prev: 1'b1, held: 1'b0,
                   lat: '{kind: K_CTRL, rd: 1'b0, second: 1'b0}};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/hpb_pack.sv
module hpb_pack #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              mirror_i,
    input  logic              cap_hi_i,
    input  logic              rd_cap_i,
    input  logic              second_i,
    input  logic [WORD_W-1:0] bus_i,
    input  logic [WORD_W-1:0] resp_i,
    output logic [WORD_W-1:0] word_o,
    output logic [WORD_W-1:0] bus_o
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [WORD_W-1:0] rword;
    } st_t;

    st_t d, q;
    logic [HALF_W-1:0] lo_in;
    logic [HALF_W-1:0] half_out;

    always_comb begin
        lo_in = bus_i[HALF_W-1:0];
        if (wide_i) begin
            word_o = bus_i;
        end else if (mirror_i) begin
            word_o = {lo_in, lo_in};
        end else begin
            word_o = {q.hi, lo_in};
        end
        half_out = second_i ? q.rword[HALF_W-1:0] : q.rword[WORD_W-1:HALF_W];
        bus_o    = wide_i ? q.rword : {{HALF_W{1'b0}}, half_out};
        d = q;
        if (cap_hi_i) d.hi = lo_in;
        if (rd_cap_i) d.rword = resp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/hpbus_front.sv
module hpbus_front
    import hpb_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode_i,
    input  logic              sel_n_i,
    input  logic              dstb0_n_i,
    input  logic              dstb1_i,
    input  logic              ale_n_i,
    input  logic              rnw_i,
    input  logic              second_i,
    input  logic [1:0]        cyc_i,
    input  logic [WORD_W-1:0] bus_i,
    output logic [WORD_W-1:0] bus_o,
    output logic              bus_oe_o,
    output logic              ready_o,
    output logic              req_wr_o,
    output logic              req_rd_o,
    output logic [1:0]        req_kind_o,
    output logic [WORD_W-1:0] req_wdata_o,
    input  logic [WORD_W-1:0] resp_data_i,
    input  logic              rd_avail_i,
    input  logic              wr_space_i
);
    typedef struct packed {
        phase_e            phase;
        kind_e             kind;
        logic              rd;
        logic              second;
        logic              req_wr;
        logic              req_rd;
        logic [WORD_W-1:0] wdata;
        logic              wide;
    } st_t;

    st_t  d, q;
    logic strb, start;
    cyc_t eff;
    logic cap_hi, mirror, is_data, fetch, wait_ok;
    logic [WORD_W-1:0] word;

    hpb_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_i  (sel_n_i),
        .dstb0_n_i(dstb0_n_i),
        .dstb1_i  (dstb1_i),
        .ale_n_i  (ale_n_i),
        .rnw_i    (rnw_i),
        .second_i (second_i),
        .cyc_i    (cyc_i),
        .strb_o   (strb),
        .start_o  (start),
        .eff_o    (eff)
    );

    hpb_pack #(.HALF_W(HALF_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide_i  (q.wide),
        .mirror_i(mirror),
        .cap_hi_i(cap_hi),
        .rd_cap_i(q.req_rd),
        .second_i(q.second),
        .bus_i   (bus_i),
        .resp_i  (resp_data_i),
        .word_o  (word),
        .bus_o   (bus_o)
    );

    always_comb begin
        d = q;
        d.req_wr = 1'b0;
        d.req_rd = 1'b0;
        cap_hi   = 1'b0;
        mirror   = (eff.kind == K_CTRL);
        is_data  = (eff.kind == K_DATA_INC) || (eff.kind == K_DATA_FIX);
        fetch    = q.wide || !eff.second;
        wait_ok  = q.rd ? rd_avail_i : wr_space_i;
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.kind   = eff.kind;
                    d.rd     = eff.rd;
                    d.second = q.wide ? 1'b0 : eff.second;
                    d.phase  = PH_ACTIVE;
                    if (eff.rd) begin
                        if (fetch) begin
                            if (is_data && !rd_avail_i) d.phase = PH_WAIT;
                            else                        d.req_rd = 1'b1;
                        end
                    end else if (!q.wide && !eff.second && !mirror) begin
                        cap_hi = 1'b1;
                    end else begin
                        d.wdata = word;
                        if (is_data && !wr_space_i) d.phase = PH_WAIT;
                        else                        d.req_wr = 1'b1;
                    end
                end
            end
            PH_ACTIVE: begin
                if (!strb) d.phase = PH_IDLE;
            end
            PH_WAIT: begin
                if (!strb) begin
                    d.phase = PH_IDLE;
                end else if (wait_ok) begin
                    d.phase  = PH_ACTIVE;
                    d.req_rd = q.rd;
                    d.req_wr = !q.rd;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase  <= PH_IDLE;
            q.kind   <= K_CTRL;
            q.rd     <= 1'b0;
            q.second <= 1'b0;
            q.req_wr <= 1'b0;
            q.req_rd <= 1'b0;
            q.wdata  <= '0;
            q.wide   <= wide_mode_i;
        end else begin
            q <= d;
        end
    end

    assign ready_o     = (q.phase != PH_WAIT);
    assign bus_oe_o    = strb && rnw_i;
    assign req_wr_o    = q.req_wr;
    assign req_rd_o    = q.req_rd;
    assign req_kind_o  = q.kind;
    assign req_wdata_o = q.wdata;
endmodule

// File: rtl/hpbus_front_chk.sv
module hpbus_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_n_i,
    input logic       dstb0_n_i,
    input logic       dstb1_i,
    input logic       rnw_i,
    input logic       bus_oe_o,
    input logic       ready_o,
    input logic       req_wr_o,
    input logic       req_rd_o,
    input logic [1:0] req_kind_o
);
    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (!sel_n_i && !dstb0_n_i && dstb1_i && rnw_i)); // R10
    AST_REQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr_o || req_rd_o) |-> $past(!sel_n_i && !dstb0_n_i && dstb1_i)); // R2
    AST_WAIT_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> req_kind_o[0]); // R9
    AST_WAIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> !(req_wr_o || req_rd_o)); // R9
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr_o || req_rd_o) |=> !(req_wr_o || req_rd_o)); // R5
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_wr_o && req_rd_o)); // R7
endmodule

bind hpbus_front hpbus_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_i   (sel_n_i),
    .dstb0_n_i (dstb0_n_i),
    .dstb1_i   (dstb1_i),
    .rnw_i     (rnw_i),
    .bus_oe_o  (bus_oe_o),
    .ready_o   (ready_o),
    .req_wr_o  (req_wr_o),
    .req_rd_o  (req_rd_o),
    .req_kind_o(req_kind_o)
);

// File: tb/hpbus_front_bench.sv
module hpbus_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode_i = 1'b0;
    logic        sel_n_i = 1'b1, dstb0_n_i = 1'b1, dstb1_i = 1'b0, ale_n_i = 1'b1;
    logic        rnw_i = 1'b0, second_i = 1'b0;
    logic [1:0]  cyc_i = 2'd0;
    logic [31:0] bus_i = '0, resp_data_i = '0;
    logic        rd_avail_i = 1'b1, wr_space_i = 1'b1;
    logic [31:0] bus_o, req_wdata_o;
    logic        bus_oe_o, ready_o, req_wr_o, req_rd_o;
    logic [1:0]  req_kind_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hpbus_front u_hpbus_front (.*);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic w);
        @(negedge clk);
        rst_n = 1'b0;
        wide_mode_i = w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic go(input logic [1:0] k, input logic rd, input logic sec, input logic [31:0] d);
        @(negedge clk);
        cyc_i = k; rnw_i = rd; second_i = sec; bus_i = d;
        sel_n_i = 1'b0; dstb0_n_i = 1'b0; dstb1_i = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic stop();
        @(negedge clk);
        sel_n_i = 1'b1; dstb0_n_i = 1'b1; dstb1_i = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        #1;
        check("R1 ready", {31'd0, ready_o}, 32'd1);
        check("R1 oe", {31'd0, bus_oe_o}, 32'd0);
        check("R1 req", {30'd0, req_wr_o, req_rd_o}, 32'd0);
    endtask

    task automatic t_bad_strobe();
        int n = 0;
        @(negedge clk);
        cyc_i = 2'd2; rnw_i = 1'b0; second_i = 1'b1; bus_i = 32'h1;
        sel_n_i = 1'b0; dstb0_n_i = 1'b1; dstb1_i = 1'b1;
        repeat (3) begin @(posedge clk); #1; n += int'(req_wr_o); end
        @(negedge clk); dstb0_n_i = 1'b0; dstb1_i = 1'b0;
        repeat (3) begin @(posedge clk); #1; n += int'(req_wr_o); end
        @(negedge clk); sel_n_i = 1'b1; dstb1_i = 1'b1;
        repeat (3) begin @(posedge clk); #1; n += int'(req_wr_o); end
        check("R2 no request on bad combos", n, 0);
        stop();
    endtask

    task automatic t_narrow_write();
        go(2'd2, 1'b0, 1'b0, 32'h0000_1234);
        check("R5 first half no req", {31'd0, req_wr_o}, 32'd0);
        stop();
        go(2'd2, 1'b0, 1'b1, 32'h0000_ABCD);
        check("R5 second half req", {31'd0, req_wr_o}, 32'd1);
        check("R5 word", req_wdata_o, 32'h1234_ABCD);
        check("R3 kind addr", {30'd0, req_kind_o}, 32'd2);
        check("R9 addr keeps ready", {31'd0, ready_o}, 32'd1);
        @(posedge clk); #1;
        check("R5 single pulse", {31'd0, req_wr_o}, 32'd0);
        stop();
    endtask

    task automatic t_ctrl_single();
        go(2'd0, 1'b0, 1'b0, 32'h0000_00C5);
        check("R6 ctrl req", {31'd0, req_wr_o}, 32'd1);
        check("R6 mirrored", req_wdata_o, 32'h00C5_00C5);
        check("R3 kind ctrl", {30'd0, req_kind_o}, 32'd0);
        stop();
    endtask

    task automatic t_narrow_read();
        resp_data_i = 32'hDEAD_BEEF; rd_avail_i = 1'b1;
        go(2'd1, 1'b1, 1'b0, 32'h0);
        check("R7 read req", {31'd0, req_rd_o}, 32'd1);
        check("R3 kind inc", {30'd0, req_kind_o}, 32'd1);
        check("R10 oe on read", {31'd0, bus_oe_o}, 32'd1);
        @(posedge clk); #1;
        check("R7 upper half", bus_o, 32'h0000_DEAD);
        stop();
        check("R10 oe off", {31'd0, bus_oe_o}, 32'd0);
        resp_data_i = 32'h0;
        go(2'd1, 1'b1, 1'b1, 32'h0);
        check("R7 no second req", {31'd0, req_rd_o}, 32'd0);
        check("R7 lower half", bus_o, 32'h0000_BEEF);
        stop();
    endtask

    task automatic t_wait_read();
        rd_avail_i = 1'b0; resp_data_i = 32'h5A5A_C3C3;
        go(2'd3, 1'b1, 1'b0, 32'h0);
        check("R9 ready low", {31'd0, ready_o}, 32'd0);
        repeat (3) @(posedge clk); #1;
        check("R9 still waiting", {30'd0, ready_o, req_rd_o}, 32'd0);
        @(negedge clk); rd_avail_i = 1'b1;
        @(posedge clk); #1;
        check("R9 release", {30'd0, ready_o, req_rd_o}, 32'd3);
        @(posedge clk); #1;
        check("R7 data after wait", bus_o, 32'h0000_5A5A);
        stop();
    endtask

    task automatic t_wait_write();
        wr_space_i = 1'b0;
        go(2'd1, 1'b0, 1'b0, 32'h0000_5555);
        check("R9 first half no wait", {30'd0, ready_o, req_wr_o}, 32'd2);
        stop();
        go(2'd1, 1'b0, 1'b1, 32'h0000_6666);
        check("R9 write wait", {30'd0, ready_o, req_wr_o}, 32'd0);
        @(posedge clk); #1;
        check("R9 write still waiting", {31'd0, ready_o}, 32'd0);
        @(negedge clk); wr_space_i = 1'b1;
        @(posedge clk); #1;
        check("R9 write release", {30'd0, ready_o, req_wr_o}, 32'd3);
        check("R5 word after wait", req_wdata_o, 32'h5555_6666);
        stop();
    endtask

    task automatic t_addr_no_wait();
        rd_avail_i = 1'b0;
        go(2'd2, 1'b1, 1'b0, 32'h0);
        check("R9 addr read no wait", {30'd0, ready_o, req_rd_o}, 32'd3);
        stop();
        rd_avail_i = 1'b1;
    endtask

    task automatic t_ale_latch();
        @(negedge clk);
        ale_n_i = 1'b0; cyc_i = 2'd2; rnw_i = 1'b1; second_i = 1'b0;
        @(posedge clk);
        go(2'd0, 1'b0, 1'b1, 32'h0000_0077);
        check("R4 latched kind", {30'd0, req_kind_o}, 32'd2);
        check("R4 latched read", {30'd0, req_wr_o, req_rd_o}, 32'd1);
        stop();
        @(negedge clk); ale_n_i = 1'b1;
        go(2'd0, 1'b0, 1'b0, 32'h0000_0011);
        check("R4 pins without latch", {30'd0, req_wr_o, req_rd_o}, 32'd2);
        check("R4 pin kind", {30'd0, req_kind_o}, 32'd0);
        stop();
    endtask

    task automatic t_wide();
        do_reset(1'b1);
        go(2'd1, 1'b0, 1'b0, 32'hCAFE_F00D);
        check("R8 wide write req", {31'd0, req_wr_o}, 32'd1);
        check("R8 wide word", req_wdata_o, 32'hCAFE_F00D);
        stop();
        resp_data_i = 32'h1357_9BDF;
        go(2'd1, 1'b1, 1'b0, 32'h0);
        check("R8 wide read req", {31'd0, req_rd_o}, 32'd1);
        @(posedge clk); #1;
        check("R8 wide read word", bus_o, 32'h1357_9BDF);
        stop();
        @(negedge clk); wide_mode_i = 1'b0;
        go(2'd2, 1'b0, 1'b0, 32'h1122_3344);
        check("R11 mode held", {31'd0, req_wr_o}, 32'd1);
        check("R11 full word", req_wdata_o, 32'h1122_3344);
        stop();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        t_reset();
        t_bad_strobe();
        t_narrow_write();
        t_ctrl_single();
        t_narrow_read();
        t_wait_read();
        t_wait_write();
        t_addr_no_wait();
        t_ale_latch();
        t_wide();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule